// File: doc/BRIEF.md
# Input Automatic Level Controller

This block drives the 6-bit gain code of an input programmable-gain amplifier. Each sample period a level detector presents a peak-level code together with a one-cycle sample strobe. The controller compares that level with a programmable target and steps the gain down (attack) when the level is above target, or up (decay) when it is below. Each step is one 0.75 dB code, and the interval between steps is counted in sample strobes.

Two modes exist. In level-holding mode a hold timer delays recovery after every loud sample. A noise gate also blocks gain increases while the input sits below a threshold, so background noise is not pumped up. In limiter mode the controller only removes gain on peaks and never raises it. Whenever the gain code lies outside the window set by the minimum and maximum gain codes, it is pulled back into range on the next clock. When the controller is switched off, the gain follows a manual gain input instead.

Top module: `alc_ctrl`

## Requirements
- R1: After reset the gain output is code 16 (0 dB; code 0 is -12 dB, code 63 is +35.25 dB, 0.75 dB per code) and the gate flag is 0.
- R2: While `alc_on` is 0, the gain output takes the value of `man_gain` on the next clock edge and the gate flag is 0. Strobes and levels have no effect.
- R3: While enabled, the window runs from code 8*m (m = `gmin_code`) up to code 8*x+7 (x = `gmax_code`). A gain above the window becomes 8*x+7, and a gain below it becomes 8*m, on the next clock edge, with or without a strobe.
- R4: While enabled and inside the window, the gain changes only on a clock edge with a strobe, and by at most one code.
- R5: A strobe with level greater than target counts toward attack. After ATK_BASE*2^`atk_code` such strobes the gain drops by one. It never drops below the window minimum.
- R6: A strobe with level below target (and not gated) counts toward decay once the hold has run out. After DCY_BASE*2^`dcy_code` such strobes the gain rises by one. It never rises above the window maximum. A level equal to the target changes nothing.
- R7: In normal mode (`lim_mode`=0), every strobe with level above target loads a hold of HLD_BASE*2^(h-1) strobes, where h = `hld_code` and codes above 10 count as 10. During the hold, below-target strobes only count the hold down. h=0 gives no hold.
- R8: In normal mode with `ng_on`=1, a strobe with level below `ng_thr` (and not above target) raises no gain and sets the gate flag. The flag clears at the next strobe whose level is at or above the threshold.
- R9: In limiter mode (`lim_mode`=1), gain is reduced as in R5 but is never raised. The hold and the noise gate are ignored, and the gate flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alc_on | input | 1 | 1 = automatic control, 0 = manual gain |
| lim_mode | input | 1 | 0 = level-holding, 1 = limiter |
| smp_stb | input | 1 | One-cycle strobe per sample |
| peak_lvl | input | LVL_W | Peak level of the current sample |
| tgt_lvl | input | LVL_W | Target level |
| gmin_code | input | 3 | Window minimum code (gain 8*m) |
| gmax_code | input | 3 | Window maximum code (gain 8*x+7) |
| atk_code | input | 4 | Attack interval exponent |
| dcy_code | input | 4 | Decay interval exponent |
| hld_code | input | 4 | Hold length code |
| ng_on | input | 1 | Noise gate enable |
| ng_thr | input | LVL_W | Noise gate threshold |
| man_gain | input | 6 | Gain used while disabled |
| gain_out | output | 6 | Current gain code (registered) |
| gate_act | output | 1 | Noise gate currently active (registered) |

## Verification
On every cycle, the assertions check the window pull-back, the one-code-per-strobe step limit, and that the gain is frozen between strobes. They also check manual following while disabled, that limiter mode never raises gain, and that a gated strobe never raises gain and sets the flag. Only the directed scenarios can show the exact interval lengths of attack, decay and hold, and how they scale with their codes. The same holds for the equal-level case, and for the gate releasing and decay resuming once the level climbs back above the threshold.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int GAIN_W = 6;
  localparam int LIM_W  = 3;
  localparam int CODE_W = 4;
  localparam logic [GAIN_W-1:0] GAIN_RESET = 6'd16;

  typedef enum logic [1:0] {
    LV_EQUAL = 2'd0,
    LV_HOT   = 2'd1,
    LV_QUIET = 2'd2,
    LV_GATED = 2'd3
  } lvl_class_e;
endpackage

// File: rtl/alc_interval.sv
module alc_interval #(
  parameter int BASE       = 1,
  parameter int TMR_W      = 20,
  parameter bit HOLD_STYLE = 0,
  parameter int CODE_CAP   = 15
) (
  input  logic [alc_pkg::CODE_W-1:0] code,
  output logic [TMR_W-1:0]           len
);
  localparam logic [alc_pkg::CODE_W-1:0] CAP = alc_pkg::CODE_W'(CODE_CAP);
  logic [alc_pkg::CODE_W-1:0] c;

  always_comb c = (code > CAP) ? CAP : code;

  generate
    if (HOLD_STYLE) begin : g_hold
      always_comb begin
        if (c == '0) len = '0;
        else         len = TMR_W'(BASE) << (c - 1'b1);
      end
    end else begin : g_plain
      always_comb len = TMR_W'(BASE) << c;
    end
  endgenerate
endmodule

// File: rtl/alc_classify.sv
module alc_classify #(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0]     lvl,
  input  logic [LVL_W-1:0]     tgt,
  input  logic [LVL_W-1:0]     thr,
  input  logic                 ng_on,
  input  logic                 lim_mode,
  output alc_pkg::lvl_class_e  cls
);
  import alc_pkg::*;
  always_comb begin
    if (lvl > tgt)                          cls = LV_HOT;
    else if (!lim_mode && ng_on && lvl < thr) cls = LV_GATED;
    else if (lvl < tgt)                     cls = LV_QUIET;
    else                                    cls = LV_EQUAL;
  end
endmodule

// File: rtl/alc_gain_core.sv
module alc_gain_core #(
  parameter int TMR_W = 20
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic                         lim,
  input  logic                         stb,
  input  alc_pkg::lvl_class_e          cls,
  input  logic [alc_pkg::GAIN_W-1:0]   wmin,
  input  logic [alc_pkg::GAIN_W-1:0]   wmax,
  input  logic [TMR_W-1:0]             atk_len,
  input  logic [TMR_W-1:0]             dcy_len,
  input  logic [TMR_W-1:0]             hld_len,
  input  logic [alc_pkg::GAIN_W-1:0]   man,
  output logic [alc_pkg::GAIN_W-1:0]   gain,
  output logic                         gate
);
  import alc_pkg::*;

  logic [TMR_W-1:0] atk_cnt, dcy_cnt, hld_cnt;
  logic [TMR_W:0]   atk_nxt, dcy_nxt;
  logic             atk_hit, dcy_hit;

  always_comb begin
    atk_nxt = {1'b0, atk_cnt} + 1'b1;
    dcy_nxt = {1'b0, dcy_cnt} + 1'b1;
    atk_hit = stb && (cls == LV_HOT) && (atk_nxt >= {1'b0, atk_len});
    dcy_hit = stb && (cls == LV_QUIET) && !lim && (hld_cnt == '0) &&
              (dcy_nxt >= {1'b0, dcy_len});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain <= GAIN_RESET;
      gate <= 1'b0;
    end else if (!en) begin
      gain <= man;
      gate <= 1'b0;
    end else begin
      if (gain > wmax)                      gain <= wmax;
      else if (gain < wmin)                 gain <= wmin;
      else if (atk_hit && gain > wmin)      gain <= gain - 1'b1;
      else if (dcy_hit && gain < wmax)      gain <= gain + 1'b1;
      if (lim)      gate <= 1'b0;
      else if (stb) gate <= (cls == LV_GATED);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      atk_cnt <= '0;
      dcy_cnt <= '0;
      hld_cnt <= '0;
    end else if (stb) begin
      case (cls)
        LV_HOT: begin
          atk_cnt <= atk_hit ? '0 : atk_nxt[TMR_W-1:0];
          dcy_cnt <= '0;
          hld_cnt <= lim ? '0 : hld_len;
        end
        LV_QUIET: begin
          atk_cnt <= '0;
          if (lim) begin
            dcy_cnt <= '0;
            hld_cnt <= '0;
          end else if (hld_cnt != '0) begin
            hld_cnt <= hld_cnt - 1'b1;
            dcy_cnt <= '0;
          end else begin
            dcy_cnt <= dcy_hit ? '0 : dcy_nxt[TMR_W-1:0];
          end
        end
        default: begin
          atk_cnt <= '0;
          dcy_cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/alc_ctrl.sv
module alc_ctrl #(
  parameter int LVL_W    = 6,
  parameter int ATK_BASE = 1,
  parameter int DCY_BASE = 2,
  parameter int HLD_BASE = 4,
  parameter int TMR_W    = 20,
  parameter int HLD_CAP  = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alc_on,
  input  logic                         lim_mode,
  input  logic                         smp_stb,
  input  logic [LVL_W-1:0]             peak_lvl,
  input  logic [LVL_W-1:0]             tgt_lvl,
  input  logic [alc_pkg::LIM_W-1:0]    gmin_code,
  input  logic [alc_pkg::LIM_W-1:0]    gmax_code,
  input  logic [alc_pkg::CODE_W-1:0]   atk_code,
  input  logic [alc_pkg::CODE_W-1:0]   dcy_code,
  input  logic [alc_pkg::CODE_W-1:0]   hld_code,
  input  logic                         ng_on,
  input  logic [LVL_W-1:0]             ng_thr,
  input  logic [alc_pkg::GAIN_W-1:0]   man_gain,
  output logic [alc_pkg::GAIN_W-1:0]   gain_out,
  output logic                         gate_act
);
  import alc_pkg::*;
  localparam int SUB_W = GAIN_W - LIM_W;

  logic [TMR_W-1:0]  atk_len, dcy_len, hld_len;
  logic [GAIN_W-1:0] wmin, wmax;
  lvl_class_e        cls;

  always_comb begin
    wmin = {gmin_code, {SUB_W{1'b0}}};
    wmax = {gmax_code, {SUB_W{1'b1}}};
  end

  alc_interval #(.BASE(ATK_BASE), .TMR_W(TMR_W), .HOLD_STYLE(1'b0), .CODE_CAP(15))
    u_atk (.code(atk_code), .len(atk_len));
  alc_interval #(.BASE(DCY_BASE), .TMR_W(TMR_W), .HOLD_STYLE(1'b0), .CODE_CAP(15))
    u_dcy (.code(dcy_code), .len(dcy_len));
  alc_interval #(.BASE(HLD_BASE), .TMR_W(TMR_W), .HOLD_STYLE(1'b1), .CODE_CAP(HLD_CAP))
    u_hld (.code(hld_code), .len(hld_len));

  alc_classify #(.LVL_W(LVL_W)) u_cls (
    .lvl(peak_lvl), .tgt(tgt_lvl), .thr(ng_thr), .ng_on(ng_on),
    .lim_mode(lim_mode), .cls(cls));

  alc_gain_core #(.TMR_W(TMR_W)) u_core (
    .clk(clk), .rst(rst), .en(alc_on), .lim(lim_mode), .stb(smp_stb),
    .cls(cls), .wmin(wmin), .wmax(wmax), .atk_len(atk_len),
    .dcy_len(dcy_len), .hld_len(hld_len), .man(man_gain),
    .gain(gain_out), .gate(gate_act));
endmodule

// File: rtl/alc_ctrl_chk.sv
module alc_ctrl_chk #(
  parameter int LVL_W = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       alc_on,
  input logic                       lim_mode,
  input logic                       smp_stb,
  input logic [LVL_W-1:0]           peak_lvl,
  input logic [LVL_W-1:0]           tgt_lvl,
  input logic [alc_pkg::LIM_W-1:0]  gmin_code,
  input logic [alc_pkg::LIM_W-1:0]  gmax_code,
  input logic                       ng_on,
  input logic [LVL_W-1:0]           ng_thr,
  input logic [alc_pkg::GAIN_W-1:0] man_gain,
  input logic [alc_pkg::GAIN_W-1:0] gain_out,
  input logic                       gate_act
);
  logic [5:0] lo, hi;
  logic       inwin;
  always_comb begin
    lo    = {gmin_code, 3'b000};
    hi    = {gmax_code, 3'b111};
    inwin = (gain_out >= lo) && (gain_out <= hi);
  end

  AST_WINDOW_PULL: assert property (@(posedge clk) disable iff (rst)
    (!rst && alc_on && gmin_code <= gmax_code) |=>
      (gain_out >= $past(lo) && gain_out <= $past(hi))); // R3

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!rst && alc_on && inwin && smp_stb) |=>
      (gain_out == $past(gain_out) || gain_out == $past(gain_out) + 6'd1 ||
       gain_out == $past(gain_out) - 6'd1)); // R4

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!rst && alc_on && inwin && !smp_stb) |=> $stable(gain_out)); // R4

  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!rst && !alc_on) |=> (gain_out == $past(man_gain) && !gate_act)); // R2

  AST_LIMIT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!rst && alc_on && lim_mode && inwin) |=>
      (gain_out <= $past(gain_out) && !gate_act)); // R9

  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!rst && alc_on && !lim_mode && ng_on && smp_stb && inwin &&
     peak_lvl < ng_thr && peak_lvl <= tgt_lvl) |=>
      (gain_out <= $past(gain_out) && gate_act)); // R8
endmodule

bind alc_ctrl alc_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .alc_on(alc_on), .lim_mode(lim_mode),
  .smp_stb(smp_stb), .peak_lvl(peak_lvl), .tgt_lvl(tgt_lvl),
  .gmin_code(gmin_code), .gmax_code(gmax_code), .ng_on(ng_on),
  .ng_thr(ng_thr), .man_gain(man_gain), .gain_out(gain_out),
  .gate_act(gate_act));

// File: tb/sim_alc_ctrl.sv
`timescale 1ns/1ps
module sim_alc_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alc_on = 1'b0, lim_mode = 1'b0, smp_stb = 1'b0, ng_on = 1'b0;
  logic [5:0] peak_lvl = '0, tgt_lvl = 6'd20, ng_thr = 6'd10, man_gain = 6'd16;
  logic [2:0] gmin_code = 3'd0, gmax_code = 3'd7;
  logic [3:0] atk_code = '0, dcy_code = '0, hld_code = '0;
  logic [5:0] gain_out;
  logic       gate_act;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  alc_ctrl u0 (
    .clk(clk), .rst(rst), .alc_on(alc_on), .lim_mode(lim_mode),
    .smp_stb(smp_stb), .peak_lvl(peak_lvl), .tgt_lvl(tgt_lvl),
    .gmin_code(gmin_code), .gmax_code(gmax_code), .atk_code(atk_code),
    .dcy_code(dcy_code), .hld_code(hld_code), .ng_on(ng_on),
    .ng_thr(ng_thr), .man_gain(man_gain), .gain_out(gain_out),
    .gate_act(gate_act));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input int n, input logic [5:0] lvl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); smp_stb = 1'b1; peak_lvl = lvl;
      @(negedge clk); smp_stb = 1'b0;
    end
  endtask

  task automatic setup(input logic [5:0] g, input logic lim,
                       input logic [2:0] mn, input logic [2:0] mx,
                       input logic [3:0] a, input logic [3:0] d,
                       input logic [3:0] h, input logic ng);
    @(negedge clk);
    alc_on = 1'b0; man_gain = g; lim_mode = lim; gmin_code = mn;
    gmax_code = mx; atk_code = a; dcy_code = d; hld_code = h; ng_on = ng;
    @(negedge clk);
    alc_on = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 reset gain", gain_out, 16);
    chk("R1 reset gate", gate_act, 0);
  endtask

  task automatic t_manual();
    @(negedge clk); alc_on = 1'b0; man_gain = 6'd12;
    @(negedge clk); chk("R2 manual follow", gain_out, 12);
    strobe(3, 6'd40);
    chk("R2 strobes ignored", gain_out, 12);
    chk("R2 gate low", gate_act, 0);
  endtask

  task automatic t_snap();
    setup(6'd63, 0, 3'd0, 3'd3, 4'd0, 4'd0, 4'd0, 0);
    @(negedge clk); chk("R3 pull down to max", gain_out, 31);
    gmax_code = 3'd7; gmin_code = 3'd5;
    @(negedge clk); chk("R3 pull up to min", gain_out, 40);
  endtask

  task automatic t_attack();
    setup(6'd40, 0, 3'd0, 3'd7, 4'd0, 4'd0, 4'd0, 0);
    strobe(3, 6'd30);
    chk("R5 attack len1", gain_out, 37);
    @(negedge clk); atk_code = 4'd1;
    strobe(1, 6'd30);
    chk("R5 attack len2 first", gain_out, 37);
    strobe(1, 6'd30);
    chk("R5 attack len2 second", gain_out, 36);
    repeat (3) @(negedge clk);
    chk("R4 no strobe no change", gain_out, 36);
  endtask

  task automatic t_hold();
    setup(6'd40, 0, 3'd0, 3'd7, 4'd0, 4'd0, 4'd1, 0);
    strobe(1, 6'd30);
    chk("R7 hot step", gain_out, 39);
    strobe(4, 6'd5);
    chk("R7 held", gain_out, 39);
    strobe(1, 6'd5);
    chk("R6 decay count 1", gain_out, 39);
    strobe(1, 6'd5);
    chk("R6 decay step", gain_out, 40);
    setup(6'd40, 0, 3'd0, 3'd7, 4'd0, 4'd0, 4'd0, 0);
    strobe(1, 6'd30);
    strobe(1, 6'd5);
    chk("R7 no hold count 1", gain_out, 39);
    strobe(1, 6'd5);
    chk("R7 no hold step", gain_out, 40);
    strobe(5, 6'd20);
    chk("R6 equal level no change", gain_out, 40);
  endtask

  task automatic t_bounds();
    setup(6'd30, 0, 3'd0, 3'd3, 4'd0, 4'd0, 4'd0, 0);
    strobe(6, 6'd5);
    chk("R6 stop at max", gain_out, 31);
    setup(6'd2, 0, 3'd0, 3'd7, 4'd0, 4'd0, 4'd0, 0);
    strobe(5, 6'd40);
    chk("R5 stop at min", gain_out, 0);
  endtask

  task automatic t_gate();
    setup(6'd30, 0, 3'd0, 3'd7, 4'd0, 4'd0, 4'd0, 1);
    strobe(6, 6'd5);
    chk("R8 gated no rise", gain_out, 30);
    chk("R8 gate flag set", gate_act, 1);
    strobe(1, 6'd15);
    chk("R8 gate flag clear", gate_act, 0);
    chk("R8 count after gate", gain_out, 30);
    strobe(1, 6'd15);
    chk("R8 rise after gate", gain_out, 31);
  endtask

  task automatic t_limit();
    setup(6'd30, 1, 3'd0, 3'd7, 4'd0, 4'd0, 4'd1, 1);
    strobe(6, 6'd5);
    chk("R9 limiter no rise", gain_out, 30);
    chk("R9 limiter gate low", gate_act, 0);
    strobe(2, 6'd40);
    chk("R9 limiter cuts", gain_out, 28);
    strobe(4, 6'd15);
    chk("R9 limiter no recovery", gain_out, 28);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_manual();
    t_snap();
    t_attack();
    t_hold();
    t_bounds();
    t_gate();
    t_limit();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule